// File: doc/BRIEF.md
# Limited-Pointer Sharer Tracker

This block holds the identities of the nodes that share each line of a directory. Each line gets a small fixed number of node-ID slots with a valid bit per slot, not a bit vector with one bit per node. A vector of that kind needs storage that grows with the square of the node count. When a line has few sharers, adding, clearing and reading its sharers all happen in hardware and need no software help.

When a new sharer arrives at a line whose slots are all in use, the parameter `TRAP_MODE` picks one of two behaviours. With `TRAP_MODE=1`, the line's overflow flag is set and a trap request is raised to a software handler. The request carries the line and the extra node, so that software can keep that sharer in ordinary memory. The request stays up until the handler acknowledges it, and until then adds to that line stall. With `TRAP_MODE=0`, the oldest slot is evicted instead and an invalidate is requested for the evicted node, so the number of sharers never goes above the slot count.

A read operation returns the valid slots of a line, packed in slot order, together with the overflow flag. An invalidation sequencer can walk this result.

Top module: `sharer_tracker`

## Requirements
- R1: After reset, `trap_req_o`, `inv_req_o` and `rd_valid_o` are 0, and every line reads back with mask 0 and overflow 0.
- R2: Opcodes on `op_i` are 0 = idle, 1 = add, 2 = clear, 3 = read. An add of a node that is not yet present, to a line with a free slot, stores the node in the lowest-numbered free slot and sets that slot's valid bit.
- R3: An add of a node ID that some valid slot of the line already holds leaves the line unchanged and uses no slot.
- R4: With `TRAP_MODE=1`, an accepted add of a new node to a full line sets the line's overflow flag and leaves its slots unchanged. One cycle later, `trap_req_o` is high, with `trap_line_o` and `trap_node_o` giving the line and the node.
- R5: `trap_req_o` stays high, with stable line and node, until a cycle in which `trap_ack_i` is high. It is low in the cycle after that one.
- R6: While a trap is pending, `op_ready_o` is low for an add to the trapped line and for an add that would itself need a trap. Such an add has no effect. Every other operation keeps `op_ready_o` high.
- R7: A clear resets every valid bit of the line and its overflow flag in a single cycle.
- R8: With `TRAP_MODE=0`, an add of a new node to a full line evicts slot 0. The remaining slots move down by one, the new node goes into the last slot, and the overflow flag stays 0. One cycle later, `inv_req_o` pulses high for one cycle with `inv_node_o` set to the evicted node. No trap is raised in this mode.
- R9: One cycle after a read, `rd_valid_o` pulses high for one cycle. Slot i of the result is at `rd_ptrs_o[i*NODE_W +: NODE_W]` with its valid bit at `rd_mask_o[i]`. Invalid slots read as zero, and the valid slots always form a prefix starting at slot 0. The line's overflow flag appears on `rd_ovf_o`.
- R10: An operation on one line does not change the contents of any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Opcode: 0 idle, 1 add, 2 clear, 3 read |
| line_i | input | $clog2(NUM_LINES) | Target line |
| node_i | input | NODE_W | Node ID for an add |
| op_ready_o | output | 1 | Low when the presented add is stalled |
| rd_valid_o | output | 1 | Read result valid |
| rd_mask_o | output | NUM_PTRS | Valid bit of each slot |
| rd_ptrs_o | output | NUM_PTRS*NODE_W | Slot node IDs, slot 0 in the low bits |
| rd_ovf_o | output | 1 | Overflow flag of the line that was read |
| trap_req_o | output | 1 | Software trap request |
| trap_line_o | output | $clog2(NUM_LINES) | Line that overflowed |
| trap_node_o | output | NODE_W | Node that did not fit |
| trap_ack_i | input | 1 | Handler acknowledge |
| inv_req_o | output | 1 | Invalidate request for an evicted sharer |
| inv_node_o | output | NODE_W | Evicted node |

## Verification
The results of an accepted operation arrive at different times. The line store changes at the edge where the operation is taken. The trap request, the invalidate pulse and the read result each come from a register and appear one edge after their operation. The only same-cycle result is `op_ready_o`, which is combinational. The bench drives inputs on the falling edge. It checks `op_ready_o` just after it sets the inputs, and it samples registered results on the first falling edge after the rising edge that took the operation. Line contents are always checked through a later read, so that a write and its read-back never fall in the same cycle.

// File: rtl/sharer_pkg.sv
package sharer_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_ADD   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_READ  = 2'd3
  } shr_op_e;
endpackage

// File: rtl/shr_update.sv
// Next-state of one line for add / clear; purely combinational.
module shr_update #(
  parameter int P         = 4,
  parameter int W         = 6,
  parameter int TRAP_MODE = 1
) (
  input  logic           add_i,
  input  logic           clr_i,
  input  logic [P-1:0]   vld_i,
  input  logic [P*W-1:0] ptr_i,
  input  logic           ovf_i,
  input  logic [W-1:0]   node_i,
  output logic [P-1:0]   vld_o,
  output logic [P*W-1:0] ptr_o,
  output logic           ovf_o,
  output logic           need_trap_o,
  output logic           evict_o,
  output logic [W-1:0]   evict_node_o
);
  logic hit, full, placed;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < P; i++)
      if (vld_i[i] && ptr_i[i*W +: W] == node_i) hit = 1'b1;
    full        = &vld_i;
    vld_o       = vld_i;
    ptr_o       = ptr_i;
    ovf_o       = ovf_i;
    need_trap_o = 1'b0;
    evict_o     = 1'b0;
    placed      = 1'b0;
    if (clr_i) begin
      vld_o = '0;
      ovf_o = 1'b0;
    end else if (add_i && !hit) begin
      if (!full) begin
        for (int i = 0; i < P; i++)
          if (!vld_i[i] && !placed) begin
            vld_o[i]        = 1'b1;
            ptr_o[i*W +: W] = node_i;
            placed          = 1'b1;
          end
      end else if (TRAP_MODE != 0) begin
        ovf_o       = 1'b1;
        need_trap_o = 1'b1;
      end else begin
        // oldest sharer leaves from slot 0, arrival order preserved
        evict_o = 1'b1;
        ptr_o   = {node_i, ptr_i[P*W-1:W]};
      end
    end
  end

  assign evict_node_o = ptr_i[W-1:0];
endmodule

// File: rtl/shr_store.sv
module shr_store #(
  parameter int P  = 4,
  parameter int W  = 6,
  parameter int L  = 16,
  localparam int LW = (L > 1) ? $clog2(L) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [LW-1:0]  line_i,
  input  logic [P-1:0]   vld_i,
  input  logic [P*W-1:0] ptr_i,
  input  logic           ovf_i,
  output logic [P-1:0]   vld_o,
  output logic [P*W-1:0] ptr_o,
  output logic           ovf_o
);
  logic [P-1:0]   vld_q [L];
  logic [P*W-1:0] ptr_q [L];
  logic [L-1:0]   ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < L; l++) begin
        vld_q[l] <= '0;
        ptr_q[l] <= '0;
      end
      ovf_q <= '0;
    end else if (we_i) begin
      for (int l = 0; l < L; l++)
        if (line_i == LW'(l)) begin
          vld_q[l] <= vld_i;
          ptr_q[l] <= ptr_i;
          ovf_q[l] <= ovf_i;
        end
    end
  end

  assign vld_o = vld_q[line_i];
  assign ptr_o = ptr_q[line_i];
  assign ovf_o = ovf_q[line_i];
endmodule

// File: rtl/shr_trap.sv
module shr_trap #(
  parameter int W  = 6,
  parameter int LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [LW-1:0] line_i,
  input  logic [W-1:0]  node_i,
  input  logic          ack_i,
  output logic          pend_o,
  output logic [LW-1:0] line_o,
  output logic [W-1:0]  node_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      line_o <= '0;
      node_o <= '0;
    end else if (set_i) begin
      pend_o <= 1'b1;
      line_o <= line_i;
      node_o <= node_i;
    end else if (ack_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sharer_tracker.sv
module sharer_tracker
  import sharer_pkg::*;
#(
  parameter int NUM_PTRS  = 4,
  parameter int NODE_W    = 6,
  parameter int NUM_LINES = 16,
  parameter int TRAP_MODE = 1,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int PW = NUM_PTRS * NODE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  input  logic [1:0]          op_i,
  input  logic [LW-1:0]       line_i,
  input  logic [NODE_W-1:0]   node_i,
  output logic                op_ready_o,
  output logic                rd_valid_o,
  output logic [NUM_PTRS-1:0] rd_mask_o,
  output logic [PW-1:0]       rd_ptrs_o,
  output logic                rd_ovf_o,
  output logic                trap_req_o,
  output logic [LW-1:0]       trap_line_o,
  output logic [NODE_W-1:0]   trap_node_o,
  input  logic                trap_ack_i,
  output logic                inv_req_o,
  output logic [NODE_W-1:0]   inv_node_o
);
  logic is_add, is_clr, is_rd, stall, acc_add, we;
  logic [NUM_PTRS-1:0] cur_vld, nxt_vld;
  logic [PW-1:0]       cur_ptr, nxt_ptr, masked_ptr;
  logic                cur_ovf, nxt_ovf;
  logic                need_trap, evict;
  logic [NODE_W-1:0]   evict_node;

  assign is_add = op_valid_i && (op_i == OP_ADD);
  assign is_clr = op_valid_i && (op_i == OP_CLEAR);
  assign is_rd  = op_valid_i && (op_i == OP_READ);

  // one trap in flight: block the trapped line and any second overflow
  assign stall      = is_add && trap_req_o && ((line_i == trap_line_o) || need_trap);
  assign op_ready_o = !stall;
  assign acc_add    = is_add && !stall;
  assign we         = acc_add || is_clr;

  shr_store #(.P(NUM_PTRS), .W(NODE_W), .L(NUM_LINES)) u_store (
    .clk_i, .rst_ni,
    .we_i   (we),
    .line_i (line_i),
    .vld_i  (nxt_vld),
    .ptr_i  (nxt_ptr),
    .ovf_i  (nxt_ovf),
    .vld_o  (cur_vld),
    .ptr_o  (cur_ptr),
    .ovf_o  (cur_ovf)
  );

  shr_update #(.P(NUM_PTRS), .W(NODE_W), .TRAP_MODE(TRAP_MODE)) u_update (
    .add_i        (is_add),
    .clr_i        (is_clr),
    .vld_i        (cur_vld),
    .ptr_i        (cur_ptr),
    .ovf_i        (cur_ovf),
    .node_i       (node_i),
    .vld_o        (nxt_vld),
    .ptr_o        (nxt_ptr),
    .ovf_o        (nxt_ovf),
    .need_trap_o  (need_trap),
    .evict_o      (evict),
    .evict_node_o (evict_node)
  );

  shr_trap #(.W(NODE_W), .LW(LW)) u_trap (
    .clk_i, .rst_ni,
    .set_i  (acc_add && need_trap),
    .line_i (line_i),
    .node_i (node_i),
    .ack_i  (trap_ack_i),
    .pend_o (trap_req_o),
    .line_o (trap_line_o),
    .node_o (trap_node_o)
  );

  always_comb begin
    for (int i = 0; i < NUM_PTRS; i++)
      masked_ptr[i*NODE_W +: NODE_W] = cur_vld[i] ? cur_ptr[i*NODE_W +: NODE_W] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_mask_o  <= '0;
      rd_ptrs_o  <= '0;
      rd_ovf_o   <= 1'b0;
      inv_req_o  <= 1'b0;
      inv_node_o <= '0;
    end else begin
      rd_valid_o <= is_rd;
      if (is_rd) begin
        rd_mask_o <= cur_vld;
        rd_ptrs_o <= masked_ptr;
        rd_ovf_o  <= cur_ovf;
      end
      inv_req_o <= acc_add && evict;
      if (acc_add && evict) inv_node_o <= evict_node;
    end
  end
endmodule

// File: rtl/sharer_tracker_chk.sv
module sharer_tracker_chk #(
  parameter int NUM_PTRS  = 4,
  parameter int NODE_W    = 6,
  parameter int NUM_LINES = 16,
  parameter int TRAP_MODE = 1,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int PW = NUM_PTRS * NODE_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                op_valid_i,
  input logic [1:0]          op_i,
  input logic [LW-1:0]       line_i,
  input logic [NODE_W-1:0]   node_i,
  input logic                op_ready_o,
  input logic                rd_valid_o,
  input logic [NUM_PTRS-1:0] rd_mask_o,
  input logic [PW-1:0]       rd_ptrs_o,
  input logic                rd_ovf_o,
  input logic                trap_req_o,
  input logic [LW-1:0]       trap_line_o,
  input logic [NODE_W-1:0]   trap_node_o,
  input logic                trap_ack_i,
  input logic                inv_req_o,
  input logic [NODE_W-1:0]   inv_node_o
);
  logic [NUM_PTRS-1:0] mask_inc;
  assign mask_inc = rd_mask_o + 1'b1;

  assert_trap_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trap_req_o) |-> $past(op_valid_i && op_i == 2'd1 && op_ready_o));

  assert_trap_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o && !trap_ack_i |=> trap_req_o && $stable(trap_line_o) && $stable(trap_node_o));

  assert_trap_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o && trap_ack_i |=> !trap_req_o);

  assert_stall_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o && op_valid_i && op_i == 2'd1 && line_i == trap_line_o |-> !op_ready_o);

  assert_ready_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_req_o |-> op_ready_o);

  assert_inv_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_req_o |-> $past(op_valid_i && op_i == 2'd1 && op_ready_o));

  assert_rd_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(op_valid_i && op_i == 2'd3));

  assert_rd_prefix_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (mask_inc & rd_mask_o) == '0);

  generate
    if (TRAP_MODE == 0) begin : g_evict
      assert_no_trap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trap_req_o);
    end
  endgenerate
endmodule

bind sharer_tracker sharer_tracker_chk #(
  .NUM_PTRS(NUM_PTRS), .NODE_W(NODE_W), .NUM_LINES(NUM_LINES), .TRAP_MODE(TRAP_MODE)
) u_chk (.*);

// File: tb/sharer_tracker_test.sv
`timescale 1ns/1ps
module sharer_tracker_test;
  localparam int P = 4, W = 6, L = 16, LW = 4, PW = P * W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // trap-mode instance
  logic op_valid = 0; logic [1:0] op = 0; logic [LW-1:0] line = 0; logic [W-1:0] node = 0;
  logic trap_ack = 0;
  logic op_ready, rd_valid, rd_ovf, trap_req, inv_req;
  logic [P-1:0] rd_mask; logic [PW-1:0] rd_ptrs;
  logic [LW-1:0] trap_line; logic [W-1:0] trap_node, inv_node;

  sharer_tracker #(.NUM_PTRS(P), .NODE_W(W), .NUM_LINES(L), .TRAP_MODE(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .line_i(line), .node_i(node),
    .op_ready_o(op_ready), .rd_valid_o(rd_valid), .rd_mask_o(rd_mask), .rd_ptrs_o(rd_ptrs),
    .rd_ovf_o(rd_ovf), .trap_req_o(trap_req), .trap_line_o(trap_line), .trap_node_o(trap_node),
    .trap_ack_i(trap_ack), .inv_req_o(inv_req), .inv_node_o(inv_node));

  // evict-mode instance
  logic e_valid = 0; logic [1:0] e_op = 0; logic [LW-1:0] e_line = 0; logic [W-1:0] e_node = 0;
  logic e_ready, e_rd_valid, e_rd_ovf, e_trap_req, e_inv_req;
  logic [P-1:0] e_rd_mask; logic [PW-1:0] e_rd_ptrs;
  logic [LW-1:0] e_trap_line; logic [W-1:0] e_trap_node, e_inv_node;

  sharer_tracker #(.NUM_PTRS(P), .NODE_W(W), .NUM_LINES(L), .TRAP_MODE(0)) uut_evict (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(e_valid), .op_i(e_op), .line_i(e_line), .node_i(e_node),
    .op_ready_o(e_ready), .rd_valid_o(e_rd_valid), .rd_mask_o(e_rd_mask), .rd_ptrs_o(e_rd_ptrs),
    .rd_ovf_o(e_rd_ovf), .trap_req_o(e_trap_req), .trap_line_o(e_trap_line), .trap_node_o(e_trap_node),
    .trap_ack_i(1'b0), .inv_req_o(e_inv_req), .inv_node_o(e_inv_node));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pk(input int a, input int b, input int c, input int d);
    return {W'(d), W'(c), W'(b), W'(a)};
  endfunction

  // all tasks start and end at a falling edge
  task automatic do_op(input logic [1:0] o, input int ln, input int nd);
    op_valid = 1; op = o; line = LW'(ln); node = W'(nd);
    @(posedge clk); @(negedge clk);
    op_valid = 0; op = 0;
  endtask

  task automatic e_op_run(input logic [1:0] o, input int ln, input int nd);
    e_valid = 1; e_op = o; e_line = LW'(ln); e_node = W'(nd);
    @(posedge clk); @(negedge clk);
    e_valid = 0; e_op = 0;
  endtask

  task automatic read_chk(input int ln, input logic [P-1:0] m, input logic [PW-1:0] p,
                          input bit ov, input string req);
    do_op(2'd3, ln, 0);
    chk(rd_valid == 1'b1, req, "rd_valid", 64'(rd_valid), 1);
    chk(rd_mask == m, req, "rd_mask", 64'(rd_mask), 64'(m));
    chk(rd_ptrs == p, req, "rd_ptrs", 64'(rd_ptrs), 64'(p));
    chk(rd_ovf == ov, req, "rd_ovf", 64'(rd_ovf), 64'(ov));
  endtask

  task automatic ack_trap();
    trap_ack = 1; @(posedge clk); @(negedge clk); trap_ack = 0;
  endtask

  task automatic t_reset();
    chk(trap_req == 0, "R1", "trap_req", 64'(trap_req), 0);
    chk(inv_req == 0, "R1", "inv_req", 64'(inv_req), 0);
    chk(rd_valid == 0, "R1", "rd_valid", 64'(rd_valid), 0);
    read_chk(0, '0, '0, 0, "R1");
    read_chk(15, '0, '0, 0, "R1");
  endtask

  task automatic t_add();
    do_op(2'd1, 3, 5);
    do_op(2'd1, 3, 9);
    do_op(2'd1, 3, 9); // R3 duplicate
    do_op(2'd1, 3, 12);
    read_chk(3, 4'b0111, pk(5, 9, 12, 0), 0, "R2/R3");
    @(negedge clk);
    chk(rd_valid == 0, "R9", "rd_valid pulse", 64'(rd_valid), 0);
  endtask

  task automatic t_overflow();
    do_op(2'd1, 3, 20);
    chk(trap_req == 0, "R4", "no trap when slot free", 64'(trap_req), 0);
    do_op(2'd1, 3, 33);
    chk(trap_req == 1, "R4", "trap_req", 64'(trap_req), 1);
    chk(trap_line == 3, "R4", "trap_line", 64'(trap_line), 3);
    chk(trap_node == 33, "R4", "trap_node", 64'(trap_node), 33);
    read_chk(3, 4'b1111, pk(5, 9, 12, 20), 1, "R4");
  endtask

  task automatic t_stall();
    op_valid = 1; op = 2'd1; line = 3; node = 40;
    #1 chk(op_ready == 0, "R6", "stall trapped line", 64'(op_ready), 0);
    op_valid = 0; op = 0;
    @(negedge clk);
    op_valid = 1; op = 2'd1; line = 4; node = 7;
    #1 chk(op_ready == 1, "R6", "other line ready", 64'(op_ready), 1);
    @(posedge clk); @(negedge clk); op_valid = 0; op = 0;
    repeat (3) @(negedge clk);
    chk(trap_req == 1, "R5", "held", 64'(trap_req), 1);
    chk(trap_node == 33, "R5", "node stable", 64'(trap_node), 33);
    ack_trap();
    chk(trap_req == 0, "R5", "released", 64'(trap_req), 0);
    op_valid = 1; op = 2'd1; line = 3; node = 40;
    #1 chk(op_ready == 1, "R6", "ready after ack", 64'(op_ready), 1);
    @(posedge clk); @(negedge clk); op_valid = 0; op = 0;
    chk(trap_req == 1 && trap_node == 40, "R4", "second trap node", 64'(trap_node), 40);
    ack_trap();
  endtask

  task automatic t_clear();
    do_op(2'd2, 3, 0);
    read_chk(3, '0, '0, 0, "R7");
    read_chk(4, 4'b0001, pk(7, 0, 0, 0), 0, "R10");
    do_op(2'd1, 3, 2);
    read_chk(3, 4'b0001, pk(2, 0, 0, 0), 0, "R7/R2 reuse");
  endtask

  task automatic t_evict();
    for (int i = 1; i <= 4; i++) e_op_run(2'd1, 2, i);
    chk(e_inv_req == 0, "R8", "no inv while room", 64'(e_inv_req), 0);
    e_op_run(2'd1, 2, 5);
    chk(e_inv_req == 1, "R8", "inv_req", 64'(e_inv_req), 1);
    chk(e_inv_node == 1, "R8", "inv_node", 64'(e_inv_node), 1);
    chk(e_trap_req == 0, "R8", "no trap", 64'(e_trap_req), 0);
    @(negedge clk);
    chk(e_inv_req == 0, "R8", "inv pulse", 64'(e_inv_req), 0);
    e_op_run(2'd3, 2, 0);
    chk(e_rd_mask == 4'b1111, "R8", "mask", 64'(e_rd_mask), 64'hF);
    chk(e_rd_ptrs == pk(2, 3, 4, 5), "R8", "ptrs shifted", 64'(e_rd_ptrs), 64'(pk(2, 3, 4, 5)));
    chk(e_rd_ovf == 0, "R8", "ovf", 64'(e_rd_ovf), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_add();
    t_overflow();
    t_stall();
    t_clear();
    t_evict();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule